// File: doc/BRIEF.md
# Atomic Compare-and-Swap Memory Unit

This unit carries out one atomic compare-and-swap for a load/store pipeline on a single-ported memory. A request supplies an operand size (32-bit word or 64-bit doubleword), a byte address, a flag that marks the base as the stack pointer, a compare value, a replacement value, and a release-ordering flag. The unit checks alignment first. A misaligned request is answered with a fault and makes no memory access.

For a legal request, the unit can first drain the store buffer when release ordering is asked for. It then takes the memory lock, reads the location, and compares the value. It writes the replacement value only on a match, and releases the lock after the write or skip cycle. The response carries the old memory contents, zero-extended to 64 bits, together with a register write enable and a success bit. On a fault the register write enable stays low, so the issuing stage keeps its earlier register value. Condition flags are never touched.

The controller walks through named states:
- IDLE accepts a request. It goes to RESPOND on a fault, to DRAIN when release is set, and to LOCK_READ otherwise.
- DRAIN waits for the store buffer to report empty, then goes to LOCK_READ.
- LOCK_READ issues the read and goes to COMPARE.
- COMPARE goes to WRITE on a match and to SKIP on a mismatch.
- WRITE and SKIP both go to RESPOND.
- RESPOND returns to IDLE.

Top module: `cas_unit`

## Requirements
- R1: When the value read equals the compare value, the replacement value is written. On a mismatch no write is issued and the memory location keeps its value.
- R2: In both the match and the mismatch case, `result` equals the value read from memory, and `result_we` is 1 in the `done` cycle.
- R3: `mem_lock` is high on every memory access. It stays high from the read cycle through the WRITE or SKIP cycle, and a write is issued only in the cycle right after a completed read.
- R4: With `req_release`=1, `sb_drain_req` is held high and no memory access starts until `sb_empty` has been seen high. With `req_release`=0, `sb_drain_req` stays low.
- R5: In word size (`req_dword`=0), address bit 2 selects the lane. A value of 0 selects data bits 31:0 with `mem_be`=8'h0F, and a value of 1 selects bits 63:32 with `mem_be`=8'hF0. The replacement word is written into the selected lane only, and the returned word is zero-extended to 64 bits.
- R6: In doubleword size (`req_dword`=1), all 64 bits are compared and written with `mem_be`=8'hFF.
- R7: `flag_we` stays 0 at all times.
- R8: When `req_sp_sel`=1, address bits 3:0 must be zero. Otherwise the request faults.
- R9: A word needs address bits 1:0 to be zero and a doubleword needs bits 2:0 to be zero. Otherwise the request faults.
- R10: A faulting request makes no memory access. It signals `done` with `fault`=1, `result_we`=0, `success`=0 and `result`=0, one cycle after acceptance.
- R11: `mon_clr` pulses for exactly one cycle after each completed read, whether or not the compare matches.
- R12: `done` is a one-cycle pulse, and `success` is 1 exactly when the write was performed. Requests that arrive before `done` are ignored.
- R13: A legal request without release finishes with `done` 4 cycles after acceptance. With release it finishes 4+K cycles after acceptance, where K is the number of cycles `sb_drain_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only in IDLE |
| req_dword | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| req_addr | input | ADDR_W | Byte address |
| req_sp_sel | input | 1 | Base is the stack pointer (16-byte alignment check) |
| req_release | input | 1 | Drain earlier memory traffic before access |
| req_cmp | input | 64 | Compare value (low 32 bits used for words) |
| req_new | input | 64 | Replacement value (low 32 bits used for words) |
| sb_drain_req | output | 1 | Request to drain the store buffer |
| sb_empty | input | 1 | Store buffer reports all earlier traffic complete |
| mem_lock | output | 1 | Holds off other writers to memory |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Doubleword-aligned memory address |
| mem_be | output | 8 | Byte enables for writes |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid one cycle after a read strobe |
| mon_clr | output | 1 | Exclusive-monitor clear pulse |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Alignment fault, valid with done |
| success | output | 1 | Write was performed, valid with done |
| result | output | 64 | Old memory value, zero-extended |
| result_we | output | 1 | Compare-register write enable |
| flag_we | output | 1 | Condition-flag write enable, always 0 |

## Verification
The bench counts the cycles from the clock edge that accepts a request to the first falling edge at which `done` is seen high. It compares this count with the latency expected for the request:
- 1 cycle for a fault.
- 4 cycles for a plain operation.
- 4+K cycles with release, where the bench's store buffer model reports empty only after K drain cycles.

Read data arrives one cycle after the read strobe, so the bench samples `mon_clr` and the write one falling edge later. Memory contents and access counts are compared against the bench's own model once `done` is seen. The falling edge after that must show `done` low again.

// File: rtl/cas_pkg.sv
package cas_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_LOCK_READ,
        ST_COMPARE,
        ST_WRITE,
        ST_SKIP,
        ST_RESPOND
    } cas_state_e;
endpackage

// File: rtl/cas_align_chk.sv
module cas_align_chk #(
    parameter int ADDR_W      = 16,
    parameter int SP_ALIGN_LG = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dword,
    input  logic              sp_sel,
    output logic              misaligned
);
    localparam int WORD_LG  = 2;
    localparam int DWORD_LG = 3;

    logic nat_bad;
    logic sp_bad;

    always_comb begin
        nat_bad = dword ? (addr[DWORD_LG-1:0] != '0) : (addr[WORD_LG-1:0] != '0);
        sp_bad  = sp_sel && (addr[SP_ALIGN_LG-1:0] != '0);
        misaligned = nat_bad || sp_bad;
    end
endmodule

// File: rtl/cas_lane.sv
module cas_lane #(
    parameter int DATA_W = 64
) (
    input  logic              dword,
    input  logic              hi,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] cmp,
    input  logic [DATA_W-1:0] newv,
    output logic [DATA_W-1:0] old_ext,
    output logic              match,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W/8-1:0] be
);
    localparam int HALF   = DATA_W / 2;
    localparam int BE_W   = DATA_W / 8;
    localparam int BE_H   = BE_W / 2;

    logic [HALF-1:0] lane_word;

    always_comb begin
        lane_word = hi ? rdata[DATA_W-1:HALF] : rdata[HALF-1:0];
        if (dword) begin
            old_ext = rdata;
            match   = (rdata == cmp);
            wdata   = newv;
            be      = '1;
        end else begin
            old_ext = {{HALF{1'b0}}, lane_word};
            match   = (lane_word == cmp[HALF-1:0]);
            wdata   = {newv[HALF-1:0], newv[HALF-1:0]};
            be      = hi ? {{BE_H{1'b1}}, {BE_H{1'b0}}} : {{BE_H{1'b0}}, {BE_H{1'b1}}};
        end
    end
endmodule

// File: rtl/cas_unit.sv
module cas_unit
    import cas_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 64,
    parameter int SP_ALIGN_LG = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_dword,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_sp_sel,
    input  logic                req_release,
    input  logic [DATA_W-1:0]   req_cmp,
    input  logic [DATA_W-1:0]   req_new,
    output logic                sb_drain_req,
    input  logic                sb_empty,
    output logic                mem_lock,
    output logic                mem_en,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                mon_clr,
    output logic                done,
    output logic                fault,
    output logic                success,
    output logic [DATA_W-1:0]   result,
    output logic                result_we,
    output logic                flag_we
);
    localparam int LANE_BIT = 2;
    localparam int DW_LG    = 3;

    cas_state_e state, nxt;

    logic              req_bad;
    logic              op_dword;
    logic              op_fault;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_cmp;
    logic [DATA_W-1:0] op_new;
    logic [DATA_W-1:0] old_q;
    logic              wrote_q;
    logic [DATA_W-1:0] lane_old;
    logic              lane_match;
    logic [DATA_W-1:0] lane_wdata;
    logic [DATA_W/8-1:0] lane_be;
    logic              accept;

    cas_align_chk #(.ADDR_W(ADDR_W), .SP_ALIGN_LG(SP_ALIGN_LG)) align_i (
        .addr      (req_addr),
        .dword     (req_dword),
        .sp_sel    (req_sp_sel),
        .misaligned(req_bad)
    );

    cas_lane #(.DATA_W(DATA_W)) lane_i (
        .dword  (op_dword),
        .hi     (op_addr[LANE_BIT]),
        .rdata  (mem_rdata),
        .cmp    (op_cmp),
        .newv   (op_new),
        .old_ext(lane_old),
        .match  (lane_match),
        .wdata  (lane_wdata),
        .be     (lane_be)
    );

    assign accept = (state == ST_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_bad)          nxt = ST_RESPOND;
                    else if (req_release) nxt = ST_DRAIN;
                    else                  nxt = ST_LOCK_READ;
                end
            end
            ST_DRAIN:     if (sb_empty) nxt = ST_LOCK_READ;
            ST_LOCK_READ: nxt = ST_COMPARE;
            ST_COMPARE:   nxt = lane_match ? ST_WRITE : ST_SKIP;
            ST_WRITE:     nxt = ST_RESPOND;
            ST_SKIP:      nxt = ST_RESPOND;
            ST_RESPOND:   nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // operand and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_dword <= 1'b0;
            op_fault <= 1'b0;
            op_addr  <= '0;
            op_cmp   <= '0;
            op_new   <= '0;
            old_q    <= '0;
            wrote_q  <= 1'b0;
        end else if (accept) begin
            op_dword <= req_dword;
            op_fault <= req_bad;
            op_addr  <= req_addr;
            op_cmp   <= req_cmp;
            op_new   <= req_new;
            old_q    <= '0;
            wrote_q  <= 1'b0;
        end else if (state == ST_COMPARE) begin
            old_q    <= lane_old;
            wrote_q  <= lane_match;
        end
    end

    // outputs by state
    always_comb begin
        sb_drain_req = 1'b0;
        mem_lock     = 1'b0;
        mem_en       = 1'b0;
        mem_we       = 1'b0;
        mon_clr      = 1'b0;
        done         = 1'b0;
        fault        = 1'b0;
        success      = 1'b0;
        result_we    = 1'b0;
        result       = '0;
        flag_we      = 1'b0;
        mem_addr     = {op_addr[ADDR_W-1:DW_LG], {DW_LG{1'b0}}};
        mem_be       = lane_be;
        mem_wdata    = lane_wdata;
        unique case (state)
            ST_IDLE:      ;
            ST_DRAIN:     sb_drain_req = 1'b1;
            ST_LOCK_READ: begin
                mem_lock = 1'b1;
                mem_en   = 1'b1;
            end
            ST_COMPARE: begin
                mem_lock = 1'b1;
                mon_clr  = 1'b1;
            end
            ST_WRITE: begin
                mem_lock = 1'b1;
                mem_en   = 1'b1;
                mem_we   = 1'b1;
            end
            ST_SKIP:      mem_lock = 1'b1;
            ST_RESPOND: begin
                done      = 1'b1;
                fault     = op_fault;
                success   = wrote_q && !op_fault;
                result_we = !op_fault;
                result    = op_fault ? '0 : old_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cas_unit_chk.sv
module cas_unit_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_release,
    input logic              sb_drain_req,
    input logic              sb_empty,
    input logic              mem_lock,
    input logic              mem_en,
    input logic              mem_we,
    input logic              mon_clr,
    input logic              done,
    input logic              fault,
    input logic              success,
    input logic              result_we
);
    logic busy;
    logic pend_rel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            pend_rel <= 1'b0;
        end else begin
            if (!busy && req_valid) begin
                busy     <= 1'b1;
                pend_rel <= req_release;
            end else begin
                if (done) busy <= 1'b0;
                if (done || (sb_drain_req && sb_empty)) pend_rel <= 1'b0;
            end
        end
    end

    // R3: every memory access happens under the lock
    a_r3_access_locked: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> mem_lock);

    // R3: a write follows directly on a completed read
    a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> $past(mon_clr));

    // R4: no access while an ordered request still waits on the drain
    a_r4_no_access_before_drain: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !pend_rel);

    // R11: monitor clear only after a read strobe
    a_r11_clear_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mon_clr |-> $past(mem_en && !mem_we));

    // R10: fault never writes the register
    a_r10_fault_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (!result_we && !success));

    // R12: done is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: success only with done
    a_r12_success_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        success |-> done);
endmodule

bind cas_unit cas_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_release (req_release),
    .sb_drain_req(sb_drain_req),
    .sb_empty    (sb_empty),
    .mem_lock    (mem_lock),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mon_clr     (mon_clr),
    .done        (done),
    .fault       (fault),
    .success     (success),
    .result_we   (result_we)
);

// File: tb/cas_unit_tb_top.sv
module cas_unit_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 64;
    localparam int MEM_N  = 32;

    typedef struct packed {
        logic        dw;
        logic [15:0] addr;
        logic        sp;
        logic        rel;
        logic [3:0]  k;
        logic        cm;
        logic [63:0] cmp;
        logic [63:0] nv;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h0008, 1'b0, 1'b0, 4'd0, 1'b1, 64'd0, 64'h1111_2222_3333_4444},
        '{1'b1, 16'h0010, 1'b0, 1'b0, 4'd0, 1'b0, 64'd0, 64'h5555_6666_7777_8888},
        '{1'b0, 16'h0018, 1'b0, 1'b1, 4'd2, 1'b1, 64'd0, 64'h0000_0000_DEAD_BEEF},
        '{1'b0, 16'h001C, 1'b0, 1'b0, 4'd0, 1'b1, 64'd0, 64'hFFFF_FFFF_CAFE_F00D},
        '{1'b0, 16'h0024, 1'b0, 1'b1, 4'd1, 1'b0, 64'h0000_0000_0000_0007, 64'h0000_0000_ABCD_0123},
        '{1'b0, 16'h0022, 1'b0, 1'b0, 4'd0, 1'b1, 64'd0, 64'h0000_0000_0BAD_0BAD},
        '{1'b1, 16'h000C, 1'b0, 1'b1, 4'd2, 1'b1, 64'd0, 64'h0BAD_0BAD_0BAD_0BAD},
        '{1'b1, 16'h0028, 1'b1, 1'b0, 4'd0, 1'b1, 64'd0, 64'h0BAD_0BAD_0BAD_0BAD},
        '{1'b0, 16'h0030, 1'b1, 1'b0, 4'd0, 1'b1, 64'd0, 64'h0000_0000_1357_9BDF},
        '{1'b1, 16'h0008, 1'b0, 1'b1, 4'd3, 1'b1, 64'd0, 64'h9999_AAAA_BBBB_CCCC}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_dword = 1'b0;
    logic [ADDR_W-1:0]   req_addr = '0;
    logic                req_sp_sel = 1'b0;
    logic                req_release = 1'b0;
    logic [DATA_W-1:0]   req_cmp = '0;
    logic [DATA_W-1:0]   req_new = '0;
    logic                sb_drain_req;
    logic                sb_empty = 1'b0;
    logic                mem_lock, mem_en, mem_we;
    logic [ADDR_W-1:0]   mem_addr;
    logic [7:0]          mem_be;
    logic [DATA_W-1:0]   mem_wdata;
    logic [DATA_W-1:0]   mem_rdata;
    logic                mon_clr, done, fault, success, result_we, flag_we;
    logic [DATA_W-1:0]   result;

    int checks = 0;
    int fails  = 0;
    int rd_cnt = 0, wr_cnt = 0, mon_cnt = 0, unlocked = 0;
    logic [63:0] mem [MEM_N];

    always #4 clk = ~clk;

    cas_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dword(req_dword),
        .req_addr(req_addr), .req_sp_sel(req_sp_sel), .req_release(req_release),
        .req_cmp(req_cmp), .req_new(req_new), .sb_drain_req(sb_drain_req),
        .sb_empty(sb_empty), .mem_lock(mem_lock), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mon_clr(mon_clr), .done(done), .fault(fault),
        .success(success), .result(result), .result_we(result_we), .flag_we(flag_we)
    );

    function automatic logic [63:0] preload(int i);
        return {32'hC0DE_0000 + 32'(i), 32'h1234_0000 + 32'(i)};
    endfunction

    // memory model: one-cycle read latency, byte-enabled writes
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_N; i++) mem[i] <= preload(i);
            mem_rdata <= '0;
        end else begin
            if (mem_en) begin
                if (!mem_lock) unlocked <= unlocked + 1;
                if (mem_we) begin
                    for (int b = 0; b < 8; b++)
                        if (mem_be[b]) mem[mem_addr[7:3]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[7:3]];
                    rd_cnt <= rd_cnt + 1;
                end
            end
            if (mon_clr) mon_cnt <= mon_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input vec_t v);
        int idx, lat, dcnt, rd0, wr0, mc0, ul0;
        logic [63:0] pre, old, cmpv, expm;
        bit bad, match;
        idx  = int'(v.addr[7:3]);
        pre  = mem[idx];
        old  = v.dw ? pre : (v.addr[2] ? {32'd0, pre[63:32]} : {32'd0, pre[31:0]});
        cmpv = v.cm ? old : v.cmp;
        bad  = (v.dw ? (v.addr[2:0] != 0) : (v.addr[1:0] != 0)) || (v.sp && v.addr[3:0] != 0);
        match = !bad && (v.dw ? (cmpv == old) : (cmpv[31:0] == old[31:0]));
        expm = pre;
        if (match) expm = v.dw ? v.nv : (v.addr[2] ? {v.nv[31:0], pre[31:0]} : {pre[63:32], v.nv[31:0]});
        rd0 = rd_cnt; wr0 = wr_cnt; mc0 = mon_cnt; ul0 = unlocked;
        @(negedge clk);
        req_valid = 1'b1; req_dword = v.dw; req_addr = v.addr; req_sp_sel = v.sp;
        req_release = v.rel; req_cmp = cmpv; req_new = v.nv; sb_empty = 1'b0;
        lat = 0; dcnt = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
            if (sb_drain_req) begin
                dcnt++;
                if (rd_cnt != rd0 || wr_cnt != wr0)
                    check(0, "R4", "access during drain", 64'(rd_cnt - rd0), 0);
                sb_empty = (dcnt >= int'(v.k));
            end
        end while (!done && lat < 40);
        check(done, "R13", "done seen", 64'(done), 1);
        check(fault == bad, bad ? "R9" : "R10", "fault", 64'(fault), 64'(bad));
        if (v.sp) check(fault == bad, "R8", "sp fault", 64'(fault), 64'(bad));
        check(result_we == !bad, bad ? "R10" : "R2", "result_we", 64'(result_we), 64'(!bad));
        check(result == (bad ? 64'd0 : old), v.dw ? "R6" : "R5", "result", result, bad ? 64'd0 : old);
        check(success == match, "R12", "success", 64'(success), 64'(match));
        check(flag_we == 1'b0, "R7", "flag_we", 64'(flag_we), 0);
        check(lat == (bad ? 1 : 4 + (v.rel ? int'(v.k) : 0)), "R13", "latency", 64'(lat),
              64'(bad ? 1 : 4 + (v.rel ? int'(v.k) : 0)));
        check(dcnt == ((v.rel && !bad) ? int'(v.k) : 0), "R4", "drain cycles", 64'(dcnt),
              64'((v.rel && !bad) ? int'(v.k) : 0));
        check(rd_cnt - rd0 == (bad ? 0 : 1), "R10", "reads", 64'(rd_cnt - rd0), 64'(bad ? 0 : 1));
        check(wr_cnt - wr0 == (match ? 1 : 0), "R1", "writes", 64'(wr_cnt - wr0), 64'(match));
        check(mon_cnt - mc0 == (bad ? 0 : 1), "R11", "monitor clears", 64'(mon_cnt - mc0), 64'(!bad));
        check(unlocked == ul0, "R3", "unlocked access", 64'(unlocked - ul0), 0);
        check(mem[idx] == expm, "R1", "memory", mem[idx], expm);
        @(negedge clk);
        check(!done, "R12", "done pulse width", 64'(done), 0);
        sb_empty = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(!done && !mem_en && !mem_lock, "R12", "reset idle", {61'd0, done, mem_en, mem_lock}, 0);
        check(!sb_drain_req && !flag_we, "R7", "reset drain/flag", {62'd0, sb_drain_req, flag_we}, 0);
        check(!mon_clr, "R11", "reset monitor clear", 64'(mon_clr), 0);

        for (int i = 0; i < NV; i++) run_op(VECS[i]);

        // R12: requests during a busy operation are ignored
        begin
            logic [63:0] pre9, pre8;
            int dn;
            pre8 = mem[8];
            pre9 = mem[9];
            @(negedge clk);
            req_valid = 1'b1; req_dword = 1'b1; req_addr = 16'h0040; req_sp_sel = 1'b0;
            req_release = 1'b0; req_cmp = pre8; req_new = 64'h0123_4567_89AB_CDEF;
            @(negedge clk);
            req_addr = 16'h0048; req_cmp = pre9; req_new = '1;
            dn = 0;
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                dn += int'(done);
            end
            req_valid = 1'b0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                dn += int'(done);
            end
            check(dn == 1, "R12", "single done", 64'(dn), 1);
            check(mem[9] == pre9, "R12", "ignored request memory", mem[9], pre9);
            check(mem[8] == 64'h0123_4567_89AB_CDEF, "R1", "first op write", mem[8],
                  64'h0123_4567_89AB_CDEF);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule